// File: doc/BRIEF.md
# Digitally Filtered Window Limit Checker

This block watches a stream of 10-bit conversion results from a scanned multi-channel converter. Every result arrives with a channel number. The block checks the result against four thresholds that belong to that channel: two lower bounds and two upper bounds. With the default of 11 channels, each channel is refreshed once per 2 ms scan, so one sample arrives for each channel per scan.

A breach does not raise a fault at once. Each threshold has its own run counter, and its fault flag is set only after a chosen number of consecutive out-of-window samples. That number is 1, 2, 4 or 6. A single in-window sample clears the flag and the counter at once. Each channel also has a summary flag, which is set when any of its four threshold flags is set. A bound at the extreme of the code range turns that threshold off. The converter and the channel multiplexer are outside this block.

Top module: `wlim_checker`

## Requirements
- R1: While `rst` is high, and after it is released, every bit of `lim_fault` and `chan_fault` is 0 until an out-of-window sample arrives.
- R2: Threshold slots 0 and 1 of a channel are lower bounds, and slots 2 and 3 are upper bounds. A sample breaches a lower bound when it is strictly less than it, and an upper bound when it is strictly greater than it. A sample equal to a bound is in window.
- R3: A threshold flag is set on the Nth consecutive breaching sample of its channel. The 2-bit filter code of that threshold gives N: code 0 gives 1, code 1 gives 2, code 2 gives 4 and code 3 gives 6.
- R4: One in-window sample for a threshold clears both its flag and its run count. The flag does not change when no sample for its channel arrives.
- R5: An upper bound of 0x3FF and a lower bound of 0x000 never fault, whatever sample value arrives.
- R6: `chan_fault[c]` is the OR of `lim_fault[4c+3:4c]`. A sample only affects the counters of its own channel, so samples for other channels in between do not break a run.
- R7: A sample whose channel index is NCH or above is ignored. No flag changes.
- R8: Run counters saturate at N. A run of any length keeps the flag set and never wraps it back to clear.
- R9: For a sample accepted at clock edge E, `lim_fault` changes at edge E+1 and `chan_fault` changes at edge E+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | A sample is present this cycle |
| smp_chan | input | CW (4) | Channel number of the sample |
| smp_value | input | DW (10) | Conversion result |
| cfg_bounds | input | NCH*4*DW | Threshold for channel c, slot k, at bits [(4c+k)*DW +: DW] |
| cfg_filt | input | NCH*4*2 | Filter code for channel c, slot k, at bits [(4c+k)*2 +: 2] |
| lim_fault | output | NCH*4 | Threshold fault flags; bit 4c+k is channel c, slot k |
| chan_fault | output | NCH | Per-channel fault summary |

## Verification
Assertions check the following on every cycle:
- no run counter ever exceeds six;
- a threshold flag rises only right after a breaching update for its own channel;
- an in-window update always leaves its flag clear;
- a code-0 breach always sets the flag;
- a flag holds when no update for it arrives;
- the comparison stage never passes on an out-of-range channel;
- a channel summary rises only when one of its threshold flags was set.

Some behaviour only the bench scenarios can show:
- the exact run lengths of 2, 4 and 6;
- equality at a bound counting as in window;
- disabled extreme bounds;
- runs that continue across samples for other channels;
- long saturated runs;
- the edge-by-edge latency of both outputs.

// File: rtl/wlim_pkg.sv
package wlim_pkg;
  // Four thresholds per channel: slots 0,1 are lower bounds, 2,3 upper bounds.
  localparam int NLIM  = 4;
  localparam int NLOW  = 2;
  localparam int CNT_W = 3;

  typedef logic [1:0]       filt_code_t;
  typedef logic [CNT_W-1:0] run_cnt_t;

  // Consecutive breaches needed before a threshold faults.
  function automatic run_cnt_t run_length(input filt_code_t code);
    case (code)
      2'd0:    return run_cnt_t'(1);
      2'd1:    return run_cnt_t'(2);
      2'd2:    return run_cnt_t'(4);
      default: return run_cnt_t'(6);
    endcase
  endfunction
endpackage

// File: rtl/wlim_compare.sv
module wlim_compare
  import wlim_pkg::*;
#(
  parameter int NCH = 11,
  parameter int DW  = 10,
  parameter int CW  = $clog2(NCH)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  smp_valid,
  input  logic [CW-1:0]         smp_chan,
  input  logic [DW-1:0]         smp_value,
  input  logic [NCH*NLIM*DW-1:0] cfg_bounds,
  output logic                  cmp_valid,
  output logic [CW-1:0]         cmp_chan,
  output logic [NLIM-1:0]       cmp_breach
);
  localparam logic [CW:0] NCH_V = (CW+1)'(NCH);

  logic          in_range;
  logic [CW-1:0] sel;
  logic [NLIM-1:0] breach_d;

  assign in_range = ({1'b0, smp_chan} < NCH_V);
  assign sel      = in_range ? smp_chan : '0;

  for (genvar k = 0; k < NLIM; k++) begin : g_slot
    logic [DW-1:0] bound;
    assign bound = cfg_bounds[(int'(sel)*NLIM + k)*DW +: DW];
    if (k < NLOW) begin : g_low
      assign breach_d[k] = (smp_value < bound);
    end else begin : g_high
      assign breach_d[k] = (smp_value > bound);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_valid  <= 1'b0;
      cmp_chan   <= '0;
      cmp_breach <= '0;
    end else begin
      cmp_valid  <= smp_valid && in_range;
      cmp_chan   <= sel;
      cmp_breach <= breach_d;
    end
  end

  // R7: no out-of-range channel ever reaches the filters
  p_chan_range_r7: assert property (@(posedge clk) disable iff (rst)
    cmp_valid |-> ({1'b0, cmp_chan} < NCH_V));
endmodule

// File: rtl/wlim_filter.sv
module wlim_filter
  import wlim_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       upd,
  input  logic       breach,
  input  filt_code_t code,
  output logic       fault
);
  run_cnt_t cnt;
  run_cnt_t target;

  assign target = run_length(code);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      fault <= 1'b0;
    end else if (upd) begin
      if (!breach) begin
        cnt   <= '0;
        fault <= 1'b0;
      end else if (cnt >= target - run_cnt_t'(1)) begin
        cnt   <= target;
        fault <= 1'b1;
      end else begin
        cnt   <= cnt + run_cnt_t'(1);
      end
    end
  end

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    cnt <= run_cnt_t'(6));
  p_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (upd && !breach) |=> !fault);
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(fault));
  p_rise_cause_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(fault) |-> $past(upd && breach));
  p_single_r3: assert property (@(posedge clk) disable iff (rst)
    (upd && breach && code == 2'd0) |=> fault);
endmodule

// File: rtl/wlim_summary.sv
module wlim_summary
  import wlim_pkg::*;
#(
  parameter int NCH = 11
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NCH*NLIM-1:0] lim_fault,
  output logic [NCH-1:0]      chan_fault
);
  for (genvar c = 0; c < NCH; c++) begin : g_chan
    always_ff @(posedge clk) begin
      if (rst) chan_fault[c] <= 1'b0;
      else     chan_fault[c] <= |lim_fault[c*NLIM +: NLIM];
    end

    // R6: a summary rises only from one of its own threshold flags
    p_any_r6: assert property (@(posedge clk) disable iff (rst)
      $rose(chan_fault[c]) |-> $past(|lim_fault[c*NLIM +: NLIM]));
  end
endmodule

// File: rtl/wlim_checker.sv
module wlim_checker
  import wlim_pkg::*;
#(
  parameter int NCH = 11,
  parameter int DW  = 10,
  parameter int CW  = $clog2(NCH)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   smp_valid,
  input  logic [CW-1:0]          smp_chan,
  input  logic [DW-1:0]          smp_value,
  input  logic [NCH*NLIM*DW-1:0] cfg_bounds,
  input  logic [NCH*NLIM*2-1:0]  cfg_filt,
  output logic [NCH*NLIM-1:0]    lim_fault,
  output logic [NCH-1:0]         chan_fault
);
  logic            cmp_valid;
  logic [CW-1:0]   cmp_chan;
  logic [NLIM-1:0] cmp_breach;

  wlim_compare #(.NCH(NCH), .DW(DW), .CW(CW)) u_cmp (
    .clk(clk), .rst(rst),
    .smp_valid(smp_valid), .smp_chan(smp_chan), .smp_value(smp_value),
    .cfg_bounds(cfg_bounds),
    .cmp_valid(cmp_valid), .cmp_chan(cmp_chan), .cmp_breach(cmp_breach)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic upd;
    assign upd = cmp_valid && (cmp_chan == CW'(c));
    for (genvar k = 0; k < NLIM; k++) begin : g_slot
      wlim_filter u_flt (
        .clk(clk), .rst(rst),
        .upd(upd), .breach(cmp_breach[k]),
        .code(cfg_filt[(c*NLIM + k)*2 +: 2]),
        .fault(lim_fault[c*NLIM + k])
      );
    end
  end

  wlim_summary #(.NCH(NCH)) u_sum (
    .clk(clk), .rst(rst),
    .lim_fault(lim_fault), .chan_fault(chan_fault)
  );
endmodule

// File: tb/wlim_checker_test.sv
module wlim_checker_test;
  localparam int NCH = 11;
  localparam int DW  = 10;
  localparam int CW  = 4;
  localparam int NL  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_valid = 1'b0;
  logic [CW-1:0] smp_chan = '0;
  logic [DW-1:0] smp_value = '0;
  logic [NCH*NL*DW-1:0] cfg_bounds;
  logic [NCH*NL*2-1:0]  cfg_filt;
  logic [NCH*NL-1:0]    lim_fault;
  logic [NCH-1:0]       chan_fault;

  always #5 clk = ~clk;

  wlim_checker #(.NCH(NCH), .DW(DW), .CW(CW)) uut (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_chan(smp_chan),
    .smp_value(smp_value), .cfg_bounds(cfg_bounds), .cfg_filt(cfg_filt),
    .lim_fault(lim_fault), .chan_fault(chan_fault)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Accept at edge E (negedge drive), then wait E+1 and E+2, sample at negedge.
  task automatic put(input logic [CW-1:0] ch, input logic [DW-1:0] v);
    @(negedge clk);
    smp_valid = 1'b1; smp_chan = ch; smp_value = v;
    @(posedge clk);
    @(negedge clk);
    smp_valid = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
  endtask

  // Entry: {chan[18:15], value[14:5], expected slot flags[4:1], expected summary[0]}
  // Channel 0 slots: low 100 (N=1), low 50 (N=2), high 900 (N=4), high 950 (N=6).
  localparam logic [18:0] TBL [23] = '{
    {4'd0, 10'd500, 4'b0000, 1'b0},
    {4'd0, 10'd100, 4'b0000, 1'b0},  // equal to lower bound: in window (R2)
    {4'd0, 10'd99,  4'b0001, 1'b1},  // N=1 (R3)
    {4'd0, 10'd40,  4'b0001, 1'b1},
    {4'd0, 10'd40,  4'b0011, 1'b1},  // N=2 (R3)
    {4'd0, 10'd500, 4'b0000, 1'b0},  // single in-window clears (R4)
    {4'd0, 10'd960, 4'b0000, 1'b0},
    {4'd0, 10'd960, 4'b0000, 1'b0},
    {4'd0, 10'd960, 4'b0000, 1'b0},
    {4'd0, 10'd960, 4'b0100, 1'b1},  // N=4 (R3)
    {4'd0, 10'd960, 4'b0100, 1'b1},
    {4'd0, 10'd960, 4'b1100, 1'b1},  // N=6 (R3)
    {4'd0, 10'd960, 4'b1100, 1'b1},
    {4'd0, 10'd920, 4'b0100, 1'b1},  // only slot 3 in window (R4)
    {4'd0, 10'd900, 4'b0000, 1'b0},  // equal to upper bound (R2)
    {4'd0, 10'd960, 4'b0000, 1'b0},
    {4'd1, 10'd10,  4'b0011, 1'b1},  // other channel between (R6)
    {4'd0, 10'd960, 4'b0000, 1'b0},
    {4'd0, 10'd960, 4'b0000, 1'b0},
    {4'd0, 10'd960, 4'b0100, 1'b1},  // run not broken by channel 1 (R6)
    {4'd2, 10'd0,   4'b0000, 1'b0},  // disabled bounds (R5)
    {4'd2, 10'd1023,4'b0000, 1'b0},  // disabled bounds (R5)
    {4'd1, 10'd500, 4'b0000, 1'b0}
  };

  initial begin
    for (int c = 0; c < NCH; c++) begin
      for (int k = 0; k < NL; k++) begin
        logic [DW-1:0] b;
        logic [1:0] code;
        if (c == 2) b = (k < 2) ? 10'd0 : 10'h3FF;
        else case (k)
          0: b = 10'd100;
          1: b = 10'd50;
          2: b = 10'd900;
          default: b = 10'd950;
        endcase
        if (c == 0) code = 2'(k);
        else if (c == 1 || c == 2) code = 2'd0;
        else code = 2'd3;
        cfg_bounds[(c*NL + k)*DW +: DW] = b;
        cfg_filt[(c*NL + k)*2 +: 2] = code;
      end
    end

    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset slots", 64'(lim_fault), 64'd0);
    check("R1 reset summary", 64'(chan_fault), 64'd0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 after release", 64'(lim_fault), 64'd0);

    // Table walk: covers R2 R3 R4 R5 R6
    for (int i = 0; i < 23; i++) begin
      logic [18:0] e;
      e = TBL[i];
      put(e[18:15], e[14:5]);
      check($sformatf("table %0d R2 R3 R4 R5 R6 slots", i),
            64'(lim_fault[int'(e[18:15])*NL +: NL]), 64'(e[4:1]));
      check($sformatf("table %0d R6 summary", i),
            64'(chan_fault[int'(e[18:15])]), 64'(e[0]));
    end

    // R7: out-of-range channel indexes are ignored (channel 0 slot 2 is set now)
    begin
      logic [NCH*NL-1:0] before_l;
      logic [NCH-1:0] before_c;
      before_l = lim_fault;
      before_c = chan_fault;
      put(4'd11, 10'd500);
      put(4'd15, 10'd1023);
      put(4'd12, 10'd0);
      check("R7 slots unchanged", 64'(lim_fault), 64'(before_l));
      check("R7 summary unchanged", 64'(chan_fault), 64'(before_c));
    end

    // R8: channel 3 upper slots at N=6, a run of 20 stays set, then one clear
    for (int i = 0; i < 20; i++) begin
      put(4'd3, 10'd1000);
      if (i == 4) check("R8 before sixth", 64'(lim_fault[12 +: 4]), 64'b0000);
      if (i == 5) check("R8 sixth", 64'(lim_fault[12 +: 4]), 64'b1100);
    end
    check("R8 long run held", 64'(lim_fault[12 +: 4]), 64'b1100);
    check("R8 summary held", 64'(chan_fault[3]), 64'd1);
    put(4'd3, 10'd500);
    check("R8 R4 clear after saturation", 64'(lim_fault[12 +: 4]), 64'b0000);

    // R9: edge-exact latency, channel 1 upper slots with N=1
    @(negedge clk);
    smp_valid = 1'b1; smp_chan = 4'd1; smp_value = 10'd1000;
    @(posedge clk);
    @(negedge clk);
    smp_valid = 1'b0;
    check("R9 slots at E", 64'(lim_fault[4 +: 4]), 64'b0000);
    @(posedge clk);
    @(negedge clk);
    check("R9 slots at E+1", 64'(lim_fault[4 +: 4]), 64'b1100);
    check("R9 summary at E+1", 64'(chan_fault[1]), 64'd0);
    @(posedge clk);
    @(negedge clk);
    check("R9 summary at E+2", 64'(chan_fault[1]), 64'd1);

    // R1: reset clears set flags
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1 reset clears slots", 64'(lim_fault), 64'd0);
    check("R1 reset clears summary", 64'(chan_fault), 64'd0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule